// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial clock for a flash-card data interface from the bus clock. The time the clock spends high and the time it spends low are set separately, each in bus-clock units, so the duty cycle and rate can be tuned to the card. The output comes straight from a register and is never gated, so it cannot glitch.

Besides free running, the generator can park the clock at a chosen level. It can add an extra low phase when the data line changes direction, so that the card and the host never drive the line at the same time. It can also hold the clock in place while the shift engine asks for a pause to avoid a buffer overrun or underrun. Two single-cycle strobes tell the shift engine, in the bus-clock domain, when the serial clock has just risen or just fallen. All configuration may be changed while the clock runs. A new length only applies to the next phase that starts.

Top module: `sclk_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_out`, `rise_en` and `fall_en` are 0. The first low phase after reset lasts `cfg_low_len`+1 cycles, using the value present during reset.
- R2: In normal running, each high phase of `sclk_out` lasts `cfg_high_len`+1 bus-clock cycles (1 to 256).
- R3: In normal running, each low phase of `sclk_out` lasts `cfg_low_len`+1 bus-clock cycles (1 to 256).
- R4: A phase length is sampled when the phase starts. Rewriting `cfg_high_len` or `cfg_low_len` during a phase leaves that phase's length unchanged. The following phase uses the new value.
- R5: `rise_en` is 1 for exactly the first cycle in which `sclk_out` reads 1 after reading 0. `fall_en` is 1 for exactly the first cycle in which `sclk_out` reads 0 after reading 1. Neither strobe is asserted at any other time.
- R6: `cfg_freeze` = 2'b01 parks the clock low. A high phase in progress completes its full length, then `sclk_out` stays 0 with no strobes for as long as the code is held.
- R7: `cfg_freeze` = 2'b10 parks the clock high. A low phase in progress completes its full length, then `sclk_out` stays 1 with no strobes for as long as the code is held.
- R8: When a park code is removed, the parked level continues for a full phase of its own length, counted from the cycle in which the code changes. This cycle counts as the first cycle of that phase.
- R9: `cfg_freeze` = 2'b11 behaves exactly like 2'b00 (normal running).
- R10: While `stop_req` is 1, `sclk_out` keeps its level and the phase count does not advance. No strobe is produced. The phase in progress is lengthened by exactly the number of stopped cycles.
- R11: A one-cycle pulse on `turn_evt` adds one extra full low phase of `cfg_low_len`+1 cycles before the next rising edge. A pulse during a high phase makes the following low time 2*(`cfg_low_len`+1) cycles. Later phases are normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_high_len | input | CNT_W | High phase length minus one, in bus clocks |
| cfg_low_len | input | CNT_W | Low phase length minus one, in bus clocks |
| cfg_freeze | input | 2 | 00/11 run, 01 park low, 10 park high |
| turn_evt | input | 1 | One-cycle pulse: data line changes direction |
| stop_req | input | 1 | Pause request from the shift engine (level) |
| sclk_out | output | 1 | Serial clock towards the pad |
| rise_en | output | 1 | Strobe: first cycle after a rising edge of `sclk_out` |
| fall_en | output | 1 | Strobe: first cycle after a falling edge of `sclk_out` |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `turn_evt` is a single-cycle pulse, and that `cfg_freeze`, `stop_req` and the length fields hold a known value in every cycle after reset. The bench drives every input on the falling edge of the clock from directed tasks and keeps all of them at defined values from time zero. Each `turn_evt` pulse lasts exactly one cycle, and park and stop requests are placed inside a known phase so that the expected run lengths follow from R2 to R11.

// File: rtl/sclk_pkg.sv
// Shared definitions for the serial clock generator.
// Assumes: a two-bit park selection code, as decoded by sclk_mode_ctrl.
package sclk_pkg;

    // Park selection code applied on the cfg_freeze port.
    typedef enum logic [1:0] {
        PARK_NONE = 2'b00,
        PARK_LOW  = 2'b01,
        PARK_HIGH = 2'b10,
        PARK_NONE2 = 2'b11
    } park_sel_e;

endpackage

// File: rtl/sclk_phase_timer.sv
// Counts the bus cycles of the current serial-clock phase.
// Does: holds a latched phase length and a counter; signals the last cycle.
// Assumes: restart takes priority over hold; the length is loaded only at
// phase start (done and not held), at restart or at reset.
module sclk_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] init_len,
    input  logic             restart,
    input  logic             hold,
    input  logic [CNT_W-1:0] load_len,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;

    // Last cycle of the phase when the counter reaches the latched length.
    assign done = (cnt_q == len_q);

    // Counter and length register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= init_len;
        end else if (restart) begin
            cnt_q <= '0;
            len_q <= load_len;
        end else if (hold) begin
            cnt_q <= cnt_q;
            len_q <= len_q;
        end else if (done) begin
            cnt_q <= '0;
            len_q <= load_len;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2/R3: the count never passes the latched phase length.
    a_r3_cnt_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_q);

    // R4: the latched length only changes at a phase start or restart.
    a_r4_len_stable_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !restart) |=> $stable(len_q));

endmodule

// File: rtl/sclk_mode_ctrl.sv
// Decides, every cycle, whether the serial clock toggles, is parked, is
// paused, or inserts a turnaround low phase.
// Assumes: level is the present serial clock value; done comes from the
// phase timer; turn_evt is a single-cycle pulse.
module sclk_mode_ctrl
    import sclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  park_sel_e park_sel,
    input  logic      stop_req,
    input  logic      turn_evt,
    input  logic      level,
    input  logic      done,
    output logic      parked,
    output logic      toggle,
    output logic      stretch_now
);

    logic pend_q;
    logic boundary;

    // Parked when the requested park level has been reached.
    always_comb begin
        unique case (park_sel)
            PARK_LOW:  parked = !level;
            PARK_HIGH: parked = level;
            default:   parked = 1'b0;
        endcase
    end

    // A phase ends when its count is done and nothing holds the clock.
    assign boundary    = done && !parked && !stop_req;
    assign stretch_now = boundary && !level && pend_q;
    assign toggle      = boundary && !stretch_now;

    // Remembers a pending turnaround until an extra low phase is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (turn_evt) begin
            pend_q <= 1'b1;
        end else if (stretch_now) begin
            pend_q <= 1'b0;
        end
    end

    // R11: a pending turnaround never lets the clock rise.
    a_r11_no_rise_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !level) |-> !toggle);

    // R10: a pause request never allows a toggle.
    a_r10_stop_blocks_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !toggle);

endmodule

// File: rtl/sclk_edge_out.sv
// Holds the serial clock level and produces the rise/fall strobes.
// Does: the output comes straight from a flop, so it cannot glitch; the
// strobes are registered alongside it and mark the first cycle of a level.
// Assumes: toggle is a single-cycle decision from sclk_mode_ctrl.
module sclk_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    output logic level,
    output logic rise_en,
    output logic fall_en
);

    // Level register and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            rise_en <= 1'b0;
            fall_en <= 1'b0;
        end else begin
            level   <= level ^ toggle;
            rise_en <= toggle && !level;
            fall_en <= toggle && level;
        end
    end

endmodule

// File: rtl/sclk_gen.sv
// Top of the programmable serial clock generator.
// Does: builds the serial clock from separate high/low lengths, with park,
// pause and turnaround-stretch controls, plus edge strobes.
// Assumes: all inputs are synchronous to clk; the reset is synchronous and
// active low.
module sclk_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_high_len,
    input  logic [CNT_W-1:0] cfg_low_len,
    input  logic [1:0]       cfg_freeze,
    input  logic             turn_evt,
    input  logic             stop_req,
    output logic             sclk_out,
    output logic             rise_en,
    output logic             fall_en
);
    import sclk_pkg::*;

    park_sel_e        park_sel;
    logic             level;
    logic             done;
    logic             parked;
    logic             toggle;
    logic             stretch_now;
    logic [CNT_W-1:0] next_len;

    assign park_sel = park_sel_e'(cfg_freeze);
    assign sclk_out = level;

    // Choose the length of the phase that starts next.
    always_comb begin
        if (parked) begin
            next_len = level ? cfg_high_len : cfg_low_len;
        end else if (!level && !stretch_now) begin
            next_len = cfg_high_len;
        end else begin
            next_len = cfg_low_len;
        end
    end

    sclk_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_len (cfg_low_len),
        .restart  (parked),
        .hold     (stop_req),
        .load_len (next_len),
        .done     (done)
    );

    sclk_mode_ctrl i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .park_sel    (park_sel),
        .stop_req    (stop_req),
        .turn_evt    (turn_evt),
        .level       (level),
        .done        (done),
        .parked      (parked),
        .toggle      (toggle),
        .stretch_now (stretch_now)
    );

    sclk_edge_out i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .toggle  (toggle),
        .level   (level),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    // R5: rise strobe only in the first cycle of a high level.
    a_r5_rise_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rise_en |-> (sclk_out && !$past(sclk_out)));

    // R5: fall strobe only in the first cycle of a low level.
    a_r5_fall_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en |-> (!sclk_out && $past(sclk_out)));

    // R10: a pause keeps the clock level.
    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> $stable(sclk_out));

    // R6: once low under a park-low request, the clock stays low.
    a_r6_park_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_freeze == 2'b01 && !sclk_out) |=> !sclk_out);

    // R7: once high under a park-high request, the clock stays high.
    a_r7_park_high_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_freeze == 2'b10 && sclk_out) |=> sclk_out);

    // R1: outputs are quiet in reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sclk_out && !rise_en && !fall_en));

endmodule

// File: tb/test_sclk_gen.sv
// Directed bench for sclk_gen: one task per scenario, each checking itself.
module test_sclk_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int WATCHDOG = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_high_len = 8'd2;
    logic [CNT_W-1:0] cfg_low_len = 8'd3;
    logic [1:0]       cfg_freeze = 2'b00;
    logic             turn_evt = 1'b0;
    logic             stop_req = 1'b0;
    logic             sclk_out;
    logic             rise_en;
    logic             fall_en;

    int ntotal = 0;
    int nbad = 0;
    int cyc = 0;

    sclk_gen #(.CNT_W(CNT_W)) i_sclk_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_high_len (cfg_high_len),
        .cfg_low_len  (cfg_low_len),
        .cfg_freeze   (cfg_freeze),
        .turn_evt     (turn_evt),
        .stop_req     (stop_req),
        .sclk_out     (sclk_out),
        .rise_en      (rise_en),
        .fall_en      (fall_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            ntotal = ntotal + 1;
            nbad = nbad + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", ntotal, nbad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        ntotal = ntotal + 1;
        if (act !== exp) begin
            nbad = nbad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Count consecutive samples at level lvl, starting at the current one.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (sclk_out !== lvl) tick();
        while (sclk_out === lvl) begin
            n = n + 1;
            tick();
        end
    endtask

    // Move to the first sample of a fresh high phase.
    task automatic to_rise();
        while (sclk_out !== 1'b0) tick();
        while (sclk_out !== 1'b1) tick();
    endtask

    task automatic t_reset();
        int n;
        cfg_low_len = 8'd3;
        cfg_high_len = 8'd2;
        rst_n = 1'b0;
        repeat (3) tick();
        check("R1 sclk in reset", int'(sclk_out), 0);
        check("R1 strobes in reset", int'(rise_en | fall_en), 0);
        rst_n = 1'b1;
        run_len(1'b0, n);
        check("R1 first low phase", n, 4);
    endtask

    task automatic t_periods(input int h, input int l, input logic [1:0] fz, input string tag);
        int n;
        cfg_high_len = CNT_W'(h);
        cfg_low_len = CNT_W'(l);
        cfg_freeze = fz;
        to_rise();
        while (sclk_out === 1'b1) tick();
        run_len(1'b0, n);
        check({tag, " low"}, n, l + 1);
        run_len(1'b1, n);
        check({tag, " high"}, n, h + 1);
        cfg_freeze = 2'b00;
    endtask

    task automatic t_reprogram();
        int n;
        cfg_high_len = 8'd5;
        cfg_low_len = 8'd5;
        to_rise();
        to_rise();
        n = 1;
        repeat (2) begin tick(); n = n + 1; end
        cfg_high_len = 8'd1;
        cfg_low_len = 8'd2;
        while (sclk_out === 1'b1) begin n = n + 1; tick(); end
        check("R4 old high length kept", n - 1, 6);
        run_len(1'b0, n);
        check("R4 new low length", n, 3);
        run_len(1'b1, n);
        check("R4 new high length", n, 2);
    endtask

    task automatic t_strobes();
        logic prev;
        int err = 0;
        int rises = 0;
        int falls = 0;
        cfg_high_len = 8'd2;
        cfg_low_len = 8'd1;
        prev = sclk_out;
        tick();
        for (int i = 0; i < 60; i++) begin
            if (rise_en !== (sclk_out && !prev)) err = err + 1;
            if (fall_en !== (!sclk_out && prev)) err = err + 1;
            if (rise_en === 1'b1) rises = rises + 1;
            if (fall_en === 1'b1) falls = falls + 1;
            prev = sclk_out;
            tick();
        end
        check("R5 strobe alignment errors", err, 0);
        check("R5 rises seen", int'(rises > 5), 1);
        check("R5 falls seen", int'(falls > 5), 1);
    endtask

    task automatic t_park_low();
        int n;
        int bad = 0;
        cfg_high_len = 8'd4;
        cfg_low_len = 8'd3;
        to_rise();
        n = 1;
        tick(); n = n + 1;
        cfg_freeze = 2'b01;
        while (sclk_out === 1'b1) begin n = n + 1; tick(); end
        check("R6 high phase completes", n - 1, 5);
        for (int i = 0; i < 40; i++) begin
            if (sclk_out !== 1'b0 || rise_en !== 1'b0 || (i > 0 && fall_en !== 1'b0)) bad = bad + 1;
            tick();
        end
        check("R6 parked low", bad, 0);
        cfg_freeze = 2'b00;
        run_len(1'b0, n);
        check("R8 full low phase after park", n, 4);
    endtask

    task automatic t_park_high();
        int n;
        int bad = 0;
        cfg_high_len = 8'd2;
        cfg_low_len = 8'd3;
        to_rise();
        while (sclk_out === 1'b1) tick();
        n = 1;
        tick(); n = n + 1;
        cfg_freeze = 2'b10;
        while (sclk_out === 1'b0) begin n = n + 1; tick(); end
        check("R7 low phase completes", n - 1, 4);
        for (int i = 0; i < 40; i++) begin
            if (sclk_out !== 1'b1 || fall_en !== 1'b0 || (i > 0 && rise_en !== 1'b0)) bad = bad + 1;
            tick();
        end
        check("R7 parked high", bad, 0);
        cfg_freeze = 2'b00;
        run_len(1'b1, n);
        check("R8 full high phase after park", n, 3);
    endtask

    task automatic t_stop();
        int n;
        int bad = 0;
        cfg_high_len = 8'd6;
        cfg_low_len = 8'd2;
        to_rise();
        n = 1;
        repeat (2) begin tick(); n = n + 1; end
        stop_req = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (i > 0 && (sclk_out !== 1'b1 || rise_en !== 1'b0 || fall_en !== 1'b0)) bad = bad + 1;
            tick(); n = n + 1;
        end
        stop_req = 1'b0;
        while (sclk_out === 1'b1) begin n = n + 1; tick(); end
        check("R10 held during stop", bad, 0);
        check("R10 phase lengthened by stop", n - 1, 27);
    endtask

    task automatic t_turn();
        int n;
        cfg_high_len = 8'd3;
        cfg_low_len = 8'd2;
        to_rise();
        n = 1;
        turn_evt = 1'b1;
        tick(); n = n + 1;
        turn_evt = 1'b0;
        while (sclk_out === 1'b1) begin n = n + 1; tick(); end
        check("R11 high phase unchanged", n - 1, 4);
        run_len(1'b0, n);
        check("R11 stretched low time", n, 6);
        run_len(1'b1, n);
        check("R11 next high normal", n, 4);
        run_len(1'b0, n);
        check("R11 next low normal", n, 3);
    endtask

    initial begin
        t_reset();
        t_periods(2, 4, 2'b00, "R2 R3 pattern a");
        t_periods(0, 0, 2'b00, "R2 R3 minimum");
        t_periods(255, 0, 2'b00, "R2 maximum high");
        t_periods(0, 255, 2'b00, "R3 maximum low");
        t_periods(1, 3, 2'b11, "R9 code 11 runs");
        t_reprogram();
        t_strobes();
        t_park_low();
        t_park_high();
        t_stop();
        t_turn();
        $display("  test done: total=%0d bad=%0d", ntotal, nbad);
        $finish;
    end
endmodule